// File: doc/BRIEF.md
# Two-Group Prioritised Interrupt Controller

This block gathers fifteen interrupt lines (line 0 is reserved and never used) and turns them into a 4-bit request number for one processor. Each line that rises is recorded in a shared pending register. A line can instead be routed to a per-processor force register by setting its routing bit. Software can also set or clear force bits directly. A per-processor mask gates which lines reach the processor. Only processor 0's mask and force state drive the output. The other processors' registers are storage that software can read and write.

A group-select register splits the lines into an urgent group and a normal group. Whenever any urgent line is active, the request number is the highest active urgent line, even if a normal line with a higher number is active. Otherwise the request number is the highest active normal line. The processor acknowledges a serviced request by presenting its number on an acknowledge port, which retires that line. Software reaches all state through a word-wide register port with a combinational read path and single-cycle writes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq_req` is 0.
- R2: A line sets its pending bit (offset 0x04, bit n for line n) only on a 0-to-1 transition. A line held high does not set the bit again after it has been cleared.
- R3: When a line rises and its bit is set in the routing register (offset 0x14), the bit is set in every processor's force register (offset 0x80 + 4*c) and not in pending.
- R4: The active vector is (pending OR force of processor 0) AND mask of processor 0 (offset 0x40). `irq_req` is the index of the highest set bit of the selected group, or 0 when nothing is selected. It is registered, so it reflects the state as it stood before the latest clock edge.
- R5: Lines whose bit is set in the group-select register (offset 0x00) form the urgent group. When any urgent line is active, `irq_req` comes only from the urgent group.
- R6: A write to a per-processor force register sets the bits given by data[15:1] and clears the bits given by data[31:17], in the form new = (old | set) & ~clear.
- R7: A write to offset 0x08 replaces processor 0's force bits with data[15:1]. A read at 0x08 returns processor 0's force register.
- R8: Writing offset 0x0C removes the written bits from pending. Offsets 0x0C and 0x10 always read zero, and writes to pending at 0x04 are ignored.
- R9: When `ack_valid` is high with `ack_num` = n, bit n is cleared in pending and in processor 0's force register.
- R10: Bit 0 is never stored. Writes to the group-select, mask, force, routing and clear registers drop data bit 0, and bits 31:16 of these registers read zero.
- R11: If a line rises in the same cycle as a clear-register write or an acknowledge that names the same bit, the bit ends up set.
- R12: The extended registers (offset 0xC0 + 4*c) keep only data[3:0]. Unmapped offsets, and per-processor offsets for c >= NUM_CPU, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 16 | Interrupt lines; bit 0 is ignored |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_num | input | 4 | Number of the line being acknowledged |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the access (word aligned) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_req | output | 4 | Request number to processor 0; 0 means no request |

## Verification
The assertions take for granted that every access is a full, word-aligned 32-bit access, that at most one register write arrives per cycle, and that `irq_in` changes only between clock edges, so that each rise is seen at exactly one edge. The stimulus drives all inputs on the falling clock edge and issues writes only to aligned offsets. It draws interrupt lines at low density, so rises, held lines and falls all occur. Directed cases place a rise in the same cycle as a clear and as an acknowledge, and hold a line high across a clear.

// File: rtl/prio_irq_pkg.sv
// Package: shared widths and register offsets for the interrupt controller.
// Assumes byte offsets inside a 256-byte window with 4-byte registers.
package prio_irq_pkg;
    localparam int NUM_W   = 4;
    localparam int LINES   = 1 << NUM_W;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int SLOT_W  = 4;

    typedef logic [LINES-1:0] irq_vec_t;

    // Global register slots (addr[5:2] within region 0)
    localparam logic [SLOT_W-1:0] SLOT_GRP   = 4'd0;
    localparam logic [SLOT_W-1:0] SLOT_PEND  = 4'd1;
    localparam logic [SLOT_W-1:0] SLOT_ALIAS = 4'd2;
    localparam logic [SLOT_W-1:0] SLOT_CLR   = 4'd3;
    localparam logic [SLOT_W-1:0] SLOT_STAT  = 4'd4;
    localparam logic [SLOT_W-1:0] SLOT_ROUTE = 4'd5;

    // Region select (addr[7:6])
    localparam logic [1:0] RGN_GLOBAL = 2'd0;
    localparam logic [1:0] RGN_MASK   = 2'd1;
    localparam logic [1:0] RGN_FORCE  = 2'd2;
    localparam logic [1:0] RGN_EXT    = 2'd3;

    localparam irq_vec_t USABLE = ~irq_vec_t'(1);
endpackage

// File: rtl/irq_in_edge.sv
// Module: irq_in_edge
// Registers the interrupt lines and reports a one-cycle rise for each line
// that is high now and was low at the previous edge. Line 0 never rises.
// Assumes irq_in is stable around the clock edge.
module irq_in_edge
    import prio_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t lines_in,
    output irq_vec_t rise_o
);
    irq_vec_t last_q;

    // Remember the line levels seen at the previous edge
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= lines_in;
    end

    // Rise = high now, low before; reserved line removed
    always_comb rise_o = lines_in & ~last_q & USABLE;
endmodule

// File: rtl/irq_regs.sv
// Module: irq_regs
// Holds group-select, pending, routing, and per-processor mask/force/extended
// state; decodes single-cycle writes and the combinational read path.
// Assumes word-aligned full-width accesses and one write per cycle.
// A rising line always wins over a clear or acknowledge in the same cycle.
module irq_regs
    import prio_irq_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int EXT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  irq_vec_t          rise,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_valid,
    input  logic [NUM_W-1:0]  ack_num,
    output logic [DATA_W-1:0] rdata,
    output irq_vec_t          grp_o,
    output irq_vec_t          pend_o,
    output irq_vec_t          mask0_o,
    output irq_vec_t          force0_o
);
    localparam int HALF = DATA_W / 2;

    irq_vec_t grp_q, pend_q, route_q;
    irq_vec_t mask_q  [NUM_CPU];
    irq_vec_t force_q [NUM_CPU];
    logic [EXT_W-1:0] ext_q [NUM_CPU];

    logic [1:0]        rgn;
    logic [SLOT_W-1:0] slot;
    irq_vec_t          set_bits, clr_bits, ack_vec;
    logic              wr_glob;

    // Split the offset into region and slot, and the data into half-words
    always_comb begin
        rgn      = addr[7:6];
        slot     = addr[5:2];
        wr_glob  = wr_en && (rgn == RGN_GLOBAL);
        set_bits = irq_vec_t'(wdata[HALF-1:0]) & USABLE;
        clr_bits = irq_vec_t'(wdata[DATA_W-1:HALF]) & USABLE;
        ack_vec  = ack_valid ? (irq_vec_t'(1) << ack_num) & USABLE : '0;
    end

    // Group-select and routing registers: plain stores with bit 0 dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q   <= '0;
            route_q <= '0;
        end else if (wr_glob) begin
            if (slot == SLOT_GRP)   grp_q   <= set_bits;
            if (slot == SLOT_ROUTE) route_q <= set_bits;
        end
    end

    // Pending register: clear write and acknowledge first, then new rises
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            irq_vec_t nxt;
            nxt = pend_q;
            if (wr_glob && slot == SLOT_CLR) nxt = nxt & ~set_bits;
            nxt    = nxt & ~ack_vec;
            pend_q <= (nxt | (rise & ~route_q)) & USABLE;
        end
    end

    // One set of per-processor registers for each processor
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic hit;
        assign hit = (slot == SLOT_W'(c));

        // Mask and extended stores for processor c
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[c] <= '0;
                ext_q[c]  <= '0;
            end else if (wr_en && hit) begin
                if (rgn == RGN_MASK) mask_q[c] <= set_bits;
                if (rgn == RGN_EXT)  ext_q[c]  <= wdata[EXT_W-1:0];
            end
        end

        // Force register for processor c: set/clear write, alias, ack, routing
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                force_q[c] <= '0;
            end else begin
                irq_vec_t nxt;
                nxt = force_q[c];
                if (wr_en && hit && rgn == RGN_FORCE)
                    nxt = (nxt | set_bits) & ~clr_bits;
                if (c == 0) begin
                    if (wr_glob && slot == SLOT_ALIAS) nxt = set_bits;
                    nxt = nxt & ~ack_vec;
                end
                force_q[c] <= (nxt | (rise & route_q)) & USABLE;
            end
        end
    end

    // Combinational read mux over the 256-byte window
    always_comb begin
        rdata = '0;
        case (rgn)
            RGN_GLOBAL: begin
                case (slot)
                    SLOT_GRP:   rdata = DATA_W'(grp_q);
                    SLOT_PEND:  rdata = DATA_W'(pend_q);
                    SLOT_ALIAS: rdata = DATA_W'(force_q[0]);
                    SLOT_ROUTE: rdata = DATA_W'(route_q);
                    default:    rdata = '0;
                endcase
            end
            default: begin
                for (int c = 0; c < NUM_CPU; c++) begin
                    if (slot == SLOT_W'(c)) begin
                        if (rgn == RGN_MASK)  rdata = DATA_W'(mask_q[c]);
                        if (rgn == RGN_FORCE) rdata = DATA_W'(force_q[c]);
                        if (rgn == RGN_EXT)   rdata = DATA_W'(ext_q[c]);
                    end
                end
            end
        endcase
    end

    assign grp_o    = grp_q;
    assign pend_o   = pend_q;
    assign mask0_o  = mask_q[0];
    assign force0_o = force_q[0];
endmodule

// File: rtl/irq_prio.sv
// Module: irq_prio
// Forms the active vector for processor 0, picks the urgent group if it is
// non-empty, and registers the index of its highest set bit.
// Assumes bit 0 of every input vector is zero, so index 0 means idle.
module irq_prio
    import prio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  irq_vec_t         pend,
    input  irq_vec_t         force0,
    input  irq_vec_t         mask0,
    input  irq_vec_t         grp,
    output logic [NUM_W-1:0] req_o
);
    irq_vec_t         active, urgent, chosen;
    logic [NUM_W-1:0] top_idx;

    // Group selection: urgent group if any bit, else the normal group
    always_comb begin
        active = (pend | force0) & mask0;
        urgent = active & grp;
        chosen = (urgent != '0) ? urgent : (active & ~grp);
    end

    // Highest set bit: later (higher) indices overwrite earlier ones
    always_comb begin
        top_idx = '0;
        for (int i = 1; i < LINES; i++)
            if (chosen[i]) top_idx = NUM_W'(i);
    end

    // Registered request number
    always_ff @(posedge clk) begin
        if (!rst_n) req_o <= '0;
        else        req_o <= top_idx;
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: prio_irq_ctrl (top)
// Two-group prioritised interrupt controller for one processor output, with
// per-processor mask/force storage for NUM_CPU processors.
// Assumes word-aligned 32-bit register accesses and one write per cycle.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int NUM_CPU = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       irq_in,
    input  logic              ack_valid,
    input  logic [3:0]        ack_num,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [3:0]        irq_req
);
    irq_vec_t rise_w, grp_w, pend_w, mask0_w, force0_w;

    irq_in_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (irq_in),
        .rise_o   (rise_w)
    );

    irq_regs #(.NUM_CPU(NUM_CPU), .EXT_W(4)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise_w),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .ack_valid (ack_valid),
        .ack_num   (ack_num),
        .rdata     (reg_rdata),
        .grp_o     (grp_w),
        .pend_o    (pend_w),
        .mask0_o   (mask0_w),
        .force0_o  (force0_w)
    );

    irq_prio u_prio (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend_w),
        .force0 (force0_w),
        .mask0  (mask0_w),
        .grp    (grp_w),
        .req_o  (irq_req)
    );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
// Module: prio_irq_ctrl_chk
// Temporal checks on the controller, attached to every prio_irq_ctrl by bind.
// Assumes the same access rules as the top module.
module prio_irq_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  irq_req,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_rdata,
    input logic        ack_valid,
    input logic [3:0]  ack_num,
    input logic [15:0] rise,
    input logic [15:0] pend,
    input logic [15:0] force0,
    input logic [15:0] mask0,
    input logic [15:0] grp
);
    logic [15:0] act;
    assign act = (pend | force0) & mask0;

    assert_req_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != 4'd0) |-> ((($past(act) >> irq_req) & 16'd1) != 16'd0));

    assert_idle_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act) == 16'd0) |-> (irq_req == 4'd0));

    assert_urgent_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_req != 4'd0) && ($past(act & grp) != 16'd0))
            |-> ((($past(grp) >> irq_req) & 16'd1) != 16'd0));

    assert_pend_only_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~$past(pend) & ~$past(rise)) == 16'd0);

    assert_ack_retires_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_num != 4'd0 && ((rise >> ack_num) & 16'd1) == 16'd0)
            |=> (((pend >> $past(ack_num)) & 16'd1) == 16'd0));

    assert_bit0_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pend[0] && !force0[0] && !mask0[0] && !grp[0]);

    assert_writeonly_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h0C || reg_addr == 8'h10) |-> (reg_rdata == 32'd0));

    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[7:6] == 2'd0 && reg_addr[5:2] > 4'd5) |-> (reg_rdata == 32'd0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .ack_valid (ack_valid),
    .ack_num   (ack_num),
    .rise      (rise_w),
    .pend      (pend_w),
    .force0    (force0_w),
    .mask0     (mask0_w),
    .grp       (grp_w)
);

// File: tb/tb_prio_irq_ctrl.sv
// Bench: directed corner cases followed by seeded random traffic, compared
// against a behavioural model kept in bench variables.
module tb_prio_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU       = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] irq_in;
    logic        ack_valid;
    logic [3:0]  ack_num;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [3:0]  irq_req;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    prio_irq_ctrl #(.NUM_CPU(NCPU)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_valid(ack_valid),
        .ack_num(ack_num), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model state
    logic [15:0] m_grp, m_pend, m_route, m_prev;
    logic [15:0] m_mask [NCPU];
    logic [15:0] m_frc  [NCPU];
    logic [3:0]  m_ext  [NCPU];

    task automatic model_reset();
        m_grp = '0; m_pend = '0; m_route = '0; m_prev = '0;
        for (int c = 0; c < NCPU; c++) begin
            m_mask[c] = '0; m_frc[c] = '0; m_ext[c] = '0;
        end
    endtask

    function automatic logic [3:0] model_req();
        logic [15:0] a, s;
        logic [3:0] r;
        a = (m_pend | m_frc[0]) & m_mask[0];
        s = ((a & m_grp) != 0) ? (a & m_grp) : (a & ~m_grp);
        r = 0;
        for (int i = 1; i < 16; i++) if (s[i]) r = 4'(i);
        return r;
    endfunction

    function automatic logic [31:0] model_rd(logic [7:0] a);
        int c;
        c = int'(a[5:2]);
        case (a[7:6])
            2'd0: case (a[5:2])
                4'd0: return {16'd0, m_grp};
                4'd1: return {16'd0, m_pend};
                4'd2: return {16'd0, m_frc[0]};
                4'd5: return {16'd0, m_route};
                default: return 32'd0;
            endcase
            2'd1: return (c < NCPU) ? {16'd0, m_mask[c]} : 32'd0;
            2'd2: return (c < NCPU) ? {16'd0, m_frc[c]} : 32'd0;
            default: return (c < NCPU) ? {28'd0, m_ext[c]} : 32'd0;
        endcase
    endfunction

    task automatic model_apply(logic [15:0] ln, bit wr, logic [7:0] a,
                               logic [31:0] d, bit ak, logic [3:0] an);
        logic [15:0] rs, st, cl, av, rt;
        int c;
        rs = ln & ~m_prev & 16'hFFFE;
        m_prev = ln;
        rt = m_route;
        st = d[15:0] & 16'hFFFE;
        cl = d[31:16] & 16'hFFFE;
        av = ak ? ((16'd1 << an) & 16'hFFFE) : 16'd0;
        c = int'(a[5:2]);
        if (wr) begin
            case (a[7:6])
                2'd0: case (a[5:2])
                    4'd0: m_grp = st;
                    4'd2: m_frc[0] = st;
                    4'd3: m_pend = m_pend & ~st;
                    4'd5: m_route = st;
                    default: ;
                endcase
                2'd1: if (c < NCPU) m_mask[c] = st;
                2'd2: if (c < NCPU) m_frc[c] = (m_frc[c] | st) & ~cl;
                default: if (c < NCPU) m_ext[c] = d[3:0];
            endcase
        end
        m_pend   = m_pend & ~av;
        m_frc[0] = m_frc[0] & ~av;
        m_pend   = m_pend | (rs & ~rt);
        for (int k = 0; k < NCPU; k++) m_frc[k] = m_frc[k] | (rs & rt);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock cycle of stimulus; checks the registered request afterwards
    task automatic step(logic [15:0] ln, bit wr, logic [7:0] a,
                        logic [31:0] d, bit ak, logic [3:0] an);
        logic [3:0] e;
        irq_in = ln; reg_wr = wr; reg_addr = a; reg_wdata = d;
        ack_valid = ak; ack_num = an;
        e = model_req();
        model_apply(ln, wr, a, d, ak, an);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; ack_valid = 1'b0;
        check("R4 irq_req", {28'd0, irq_req}, {28'd0, e});
    endtask

    task automatic rd(string tag, logic [7:0] a);
        reg_addr = a; #1;
        check(tag, reg_rdata, model_rd(a));
    endtask

    task automatic rd_lit(string tag, logic [7:0] a, logic [31:0] lit);
        reg_addr = a; #1;
        check(tag, reg_rdata, lit);
    endtask

    logic [15:0] ln;

    initial begin
        irq_in = '0; ack_valid = 0; ack_num = 0; reg_wr = 0;
        reg_addr = 0; reg_wdata = 0; rst_n = 0;
        model_reset();
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state
        check("R1 irq_req after reset", {28'd0, irq_req}, 32'd0);
        for (int a = 0; a < 256; a += 4) rd_lit("R1 register zero", 8'(a), 32'd0);

        // R10: bit 0 and upper half dropped on stores
        step(0, 1, 8'h40, 32'hFFFF_FFFF, 0, 0);
        rd_lit("R10 mask bit0", 8'h40, 32'h0000_FFFE);
        step(0, 1, 8'h14, 32'h0000_0001, 0, 0);
        rd_lit("R10 routing bit0", 8'h14, 32'd0);
        step(0, 1, 8'h00, 32'h0001_0001, 0, 0);
        rd_lit("R10 group bit0", 8'h00, 32'd0);

        // R2: held line sets pending once
        step(16'h0020, 0, 0, 0, 0, 0);
        rd_lit("R2 pending set", 8'h04, 32'h0000_0020);
        step(16'h0020, 0, 0, 0, 0, 0);
        check("R4 req line5", {28'd0, irq_req}, 32'd5);
        step(16'h0020, 1, 8'h0C, 32'h0000_0020, 0, 0);
        step(16'h0020, 0, 0, 0, 0, 0);
        step(16'h0020, 0, 0, 0, 0, 0);
        rd_lit("R2 held line no re-set", 8'h04, 32'd0);
        check("R2 idle after clear", {28'd0, irq_req}, 32'd0);

        // R8: pending ignores writes, clear/status read zero
        step(16'h0000, 1, 8'h04, 32'h0000_FFFE, 0, 0);
        rd_lit("R8 pending write ignored", 8'h04, 32'd0);
        step(16'h0000, 1, 8'h10, 32'hFFFF_FFFF, 0, 0);
        rd_lit("R8 status reads zero", 8'h10, 32'd0);
        rd_lit("R8 clear reads zero", 8'h0C, 32'd0);

        // R5: urgent group beats higher normal line
        step(16'h0000, 1, 8'h00, 32'h0000_0008, 0, 0);
        step(16'h0208, 0, 0, 0, 0, 0);
        step(16'h0208, 0, 0, 0, 0, 0);
        check("R5 urgent line3 wins", {28'd0, irq_req}, 32'd3);
        // R9: acknowledge retires the urgent one, then the normal one shows
        step(16'h0000, 0, 0, 0, 1, 4'd3);
        step(16'h0000, 0, 0, 0, 0, 0);
        check("R9 after ack normal line9", {28'd0, irq_req}, 32'd9);
        rd_lit("R9 pending after ack", 8'h04, 32'h0000_0200);

        // R11: rise same cycle as clear and as ack
        step(16'h0000, 0, 0, 0, 0, 0);
        step(16'h0080, 1, 8'h0C, 32'h0000_0280, 0, 0);
        rd_lit("R11 rise beats clear", 8'h04, 32'h0000_0080);
        step(16'h0000, 0, 0, 0, 0, 0);
        step(16'h0080, 0, 0, 0, 1, 4'd7);
        rd_lit("R11 rise beats ack", 8'h04, 32'h0000_0080);
        step(16'h0000, 1, 8'h0C, 32'h0000_FFFE, 0, 0);

        // R3: routed line lands in every force register
        step(16'h0000, 1, 8'h14, 32'h0000_1000, 0, 0);
        step(16'h1000, 0, 0, 0, 0, 0);
        rd_lit("R3 not pending", 8'h04, 32'd0);
        for (int c = 0; c < NCPU; c++)
            rd_lit("R3 force per cpu", 8'(8'h80 + 4*c), 32'h0000_1000);

        // R6: set and clear in one write
        step(16'h0000, 1, 8'h84, 32'h1000_0006, 0, 0);
        rd_lit("R6 set/clear", 8'h84, 32'h0000_0006);
        // R7: alias replaces processor 0 force bits
        step(16'h0000, 1, 8'h08, 32'hFFFF_0041, 0, 0);
        rd_lit("R7 alias replace", 8'h80, 32'h0000_0040);
        step(16'h0000, 0, 0, 0, 0, 0);
        check("R7 forced line6 requested", {28'd0, irq_req}, 32'd6);

        // R12: extended width, unmapped and out-of-range processors
        step(16'h0000, 1, 8'hC4, 32'hFFFF_FFFF, 0, 0);
        rd_lit("R12 extended four bits", 8'hC4, 32'h0000_000F);
        step(16'h0000, 1, 8'h20, 32'hFFFF_FFFF, 0, 0);
        rd_lit("R12 unmapped zero", 8'h20, 32'd0);
        step(16'h0000, 1, 8'h4C + 8'(4*(NCPU-3)), 32'hFFFF_FFFF, 0, 0);
        rd("R12 beyond processors", 8'h4C + 8'(4*(NCPU-3)));

        // Random traffic against the model (R2..R12)
        ln = 16'h0000;
        for (int n = 0; n < 1500; n++) begin
            logic [7:0] a;
            logic [31:0] d;
            int op;
            bit wr, ak;
            if ($urandom_range(0, 2) == 0)
                ln = 16'($urandom & $urandom & $urandom);
            op = $urandom_range(0, 9);
            a  = 8'($urandom_range(0, 63) * 4);
            if (op < 2) a = 8'h0C;
            d  = $urandom;
            wr = (op < 6);
            ak = (op == 7 || op == 8);
            step(ln, wr, a, d, ak, 4'($urandom));
            rd("R12 random read", 8'($urandom_range(0, 63) * 4));
            if (n % 8 == 0) begin
                rd("R3 random force", 8'h80 + 8'(4*$urandom_range(0, NCPU-1)));
                rd("R9 random pending", 8'h04);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        done = 1'b1;
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule